// File: doc/BRIEF.md
# Sprite Attribute Scan Selector

At the start of every scanline this block walks a 160-byte object attribute memory and picks the objects whose vertical span covers the current line. The memory holds forty 4-byte records. Byte 0 of a record is the Y coordinate and byte 1 is the X coordinate; bytes 2 and 3 are never read here. A start pulse begins the scan. The block then reads the Y byte and the X byte of each record over two consecutive cycles, from an external synchronous single-port memory with one cycle of read latency. A full pass takes 80 cycles.

A record is kept when `Y <= line + 16 < Y + height`. The height is 16 lines with the tall-object input set and 8 lines without it. At most ten records are kept, in scan order. Once the tenth is held, the scan still steps over the remaining records but stores none of them. While the attribute-copy engine reports busy, records are stepped over at the same pace and never kept.

After the last record has been judged, a one-cycle completion pulse is raised. A level output also rises at that moment: it tells the display pipeline to enter its render mode and to lock out processor access to video memory. The list of kept records and the number held are visible in that cycle and stay unchanged until the next start.

Top module: `oam_scan_selector`

## Requirements
- R1: After reset, `sel_count_o` is 0, `sel_list_o` is all zero, and `done_o`, `render_mode_o` and `mem_rd_o` are low.
- R2: Take the cycle that follows the clock edge sampling `start_i` high as cycle 0. In cycles 0 to 79 `mem_rd_o` is high and `mem_addr_o` equals 4*(c/2) + (c mod 2), which gives 0,1,4,5,…,0x9C,0x9D. `mem_rd_o` is low in cycle 80.
- R3: With `tall_i` = 0, a record is kept exactly when Y <= `line_i`+16 < Y+8, computed without 8-bit wrap. Examples at line 0: Y=9 and Y=16 are kept; Y=8 and Y=17 are not.
- R4: With `tall_i` = 1 the height is 16. At line 0, Y=1 and Y=8 are kept and Y=0 is not.
- R5: Slot k sits in `sel_list_o[24*k+23 : 24*k]`. It holds the record's byte address (that is, 4 × the record index) in bits 23:16, Y in bits 15:8 and X in bits 7:0. Slots fill in increasing address order. Slots at or above `sel_count_o` read zero.
- R6: `sel_count_o` never exceeds 10. When more than ten records match, only the first ten in address order are kept.
- R7: `dma_busy_i` is sampled at the clock edge that ends a record's second cycle, the cycle with address bits 1:0 = 01. A record sampled busy is never kept, while the address sequence of R2 is unaffected.
- R8: `done_o` is high only in cycle 81 and lasts a single cycle. `render_mode_o` rises in the same cycle and stays high until the next start. The count shown in cycle 81 already includes the record at 0x9C.
- R9: `start_i` clears `sel_count_o`, the list and `render_mode_o` by cycle 0, even in the middle of a scan. The scan then restarts from address 0, and the aborted scan raises no `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that begins a scan |
| line_i | input | 8 | Current scanline number |
| tall_i | input | 1 | Object height select: 1 = 16 lines, 0 = 8 lines |
| dma_busy_i | input | 1 | Attribute-copy engine busy; records are skipped while high |
| mem_rd_o | output | 1 | Read enable to the attribute memory |
| mem_addr_o | output | 8 | Byte address to the attribute memory |
| mem_data_i | input | 8 | Read data, valid one cycle after the address |
| sel_list_o | output | 240 | Ten packed slots of {address, Y, X} |
| sel_count_o | output | 4 | Number of valid slots |
| done_o | output | 1 | One-cycle pulse when the scan has finished |
| render_mode_o | output | 1 | High from completion until the next start; blocks video memory access |

## Verification
The judgement of the final record at 0x9C and the scan-complete event land on the same clock edge. A wrong design can raise completion with a count that is one short. This is provoked by a pattern where only the last record matches, and it is judged by requiring a count of one in the completion cycle. A second collision is a start pulse during a running scan, which has to win over the address step and over any store in the same edge. It is judged by requiring an empty list in cycle 0 of the new scan and by the absence of a completion pulse from the aborted one.

// File: rtl/oam_scan_pkg.sv
package oam_scan_pkg;
  localparam int BYTE_W  = 8;
  localparam int ENTRY_W = 3 * BYTE_W;

  typedef struct packed {
    logic [BYTE_W-1:0] addr;
    logic [BYTE_W-1:0] y;
    logic [BYTE_W-1:0] x;
  } sel_entry_t;

  // Vertical coverage test done one bit wider than a byte so no term wraps.
  function automatic logic covers_line(input logic [BYTE_W-1:0] y,
                                       input logic [BYTE_W-1:0] line,
                                       input logic [BYTE_W:0]   height,
                                       input logic [BYTE_W:0]   offset);
    logic [BYTE_W:0] l_ext;
    logic [BYTE_W:0] y_ext;
    l_ext = {1'b0, line} + offset;
    y_ext = {1'b0, y};
    return (y_ext <= l_ext) && (l_ext < (y_ext + height));
  endfunction
endpackage

// File: rtl/oam_scan_seq.sv
module oam_scan_seq #(
  parameter int NUM_ENTRIES = 40,
  parameter int ENTRY_BYTES = 4,
  parameter int AW          = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  output logic          active_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [AW-1:0] entry_base_o,
  output logic          y_phase_o,
  output logic          tail_o,
  output logic          done_o,
  output logic          render_o
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);
  localparam int SUB_W = $clog2(ENTRY_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);
  localparam int SPAN  = NUM_ENTRIES * ENTRY_BYTES;

  logic             active_q;
  logic             phase_q;
  logic [IDX_W-1:0] idx_q;
  logic             tail_q;
  logic             done_q;
  logic             render_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      idx_q    <= '0;
      tail_q   <= 1'b0;
      done_q   <= 1'b0;
      render_q <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      phase_q  <= 1'b0;
      idx_q    <= '0;
      tail_q   <= 1'b0;
      done_q   <= 1'b0;
      render_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (active_q) begin
        phase_q <= ~phase_q;
        if (phase_q) begin
          if (idx_q == LAST_IDX) begin
            active_q <= 1'b0;
            tail_q   <= 1'b1;
            idx_q    <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      end
      if (tail_q) begin
        tail_q   <= 1'b0;
        done_q   <= 1'b1;
        render_q <= 1'b1;
      end
    end
  end

  assign entry_base_o = AW'({idx_q, {SUB_W{1'b0}}});
  assign mem_addr_o   = entry_base_o | AW'(phase_q);
  assign active_o     = active_q;
  assign y_phase_o    = active_q & phase_q;
  assign tail_o       = tail_q;
  assign done_o       = done_q;
  assign render_o     = render_q;

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (active_q && !phase_q && !start_i) |=> (mem_addr_o == $past(mem_addr_o) + 1'b1));
  // R2
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (int'(mem_addr_o) < SPAN));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R8
  render_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(render_q) |-> done_q);
endmodule

// File: rtl/oam_scan_match.sv
module oam_scan_match
  import oam_scan_pkg::*;
#(
  parameter int OBJ_SHORT   = 8,
  parameter int OBJ_TALL    = 16,
  parameter int LINE_OFFSET = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              y_phase_i,
  input  logic [BYTE_W-1:0] entry_base_i,
  input  logic [BYTE_W-1:0] mem_data_i,
  input  logic [BYTE_W-1:0] line_i,
  input  logic              tall_i,
  input  logic              dma_busy_i,
  output logic              eval_o,
  output logic              skip_o,
  output logic              cand_valid_o,
  output sel_entry_t        cand_o
);
  logic [BYTE_W-1:0] y_q;
  logic [BYTE_W-1:0] base_q;
  logic              skip_q;
  logic              pend_q;
  logic [BYTE_W:0]   height;
  logic              hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q    <= '0;
      base_q <= '0;
      skip_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (start_i) begin
      pend_q <= 1'b0;
      skip_q <= 1'b0;
    end else begin
      pend_q <= y_phase_i;
      if (y_phase_i) begin
        y_q    <= mem_data_i;
        base_q <= entry_base_i;
        skip_q <= dma_busy_i;
      end
    end
  end

  assign height = tall_i ? (BYTE_W+1)'(OBJ_TALL) : (BYTE_W+1)'(OBJ_SHORT);
  assign hit    = covers_line(y_q, line_i, height, (BYTE_W+1)'(LINE_OFFSET));

  assign eval_o       = pend_q;
  assign skip_o       = skip_q;
  assign cand_valid_o = pend_q & ~skip_q & hit;
  assign cand_o       = '{addr: base_q, y: y_q, x: mem_data_i};

  // R2: the Y byte of a record is never judged twice in a row
  eval_single_chk: assert property (@(posedge clk) disable iff (rst)
    pend_q |=> !pend_q);
endmodule

// File: rtl/oam_scan_list.sv
module oam_scan_list
  import oam_scan_pkg::*;
#(
  parameter int MAX_HITS = 10,
  parameter int CNT_W    = $clog2(MAX_HITS + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start_i,
  input  logic                        cand_valid_i,
  input  sel_entry_t                  cand_i,
  output logic [MAX_HITS*ENTRY_W-1:0] list_o,
  output logic [CNT_W-1:0]            count_o
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_HITS);

  sel_entry_t       slot_q [MAX_HITS];
  logic [CNT_W-1:0] count_q;
  logic             room;

  assign room = (count_q < CAP);

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      count_q <= '0;
    end else if (cand_valid_i && room) begin
      count_q <= count_q + 1'b1;
    end
  end

  for (genvar k = 0; k < MAX_HITS; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || start_i) begin
        slot_q[k] <= '0;
      end else if (cand_valid_i && room && (count_q == CNT_W'(k))) begin
        slot_q[k] <= cand_i;
      end
    end
    assign list_o[k*ENTRY_W +: ENTRY_W] = slot_q[k];
  end

  assign count_o = count_q;

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count_q <= CAP);
  // R9
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (count_q == '0));
  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> ((count_q == $past(count_q)) || (count_q == $past(count_q) + 1'b1)));
endmodule

// File: rtl/oam_scan_selector.sv
module oam_scan_selector
  import oam_scan_pkg::*;
#(
  parameter int NUM_ENTRIES = 40,
  parameter int ENTRY_BYTES = 4,
  parameter int MAX_HITS    = 10,
  parameter int OBJ_SHORT   = 8,
  parameter int OBJ_TALL    = 16,
  parameter int LINE_OFFSET = 16,
  parameter int CNT_W       = $clog2(MAX_HITS + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start_i,
  input  logic [BYTE_W-1:0]           line_i,
  input  logic                        tall_i,
  input  logic                        dma_busy_i,
  output logic                        mem_rd_o,
  output logic [BYTE_W-1:0]           mem_addr_o,
  input  logic [BYTE_W-1:0]           mem_data_i,
  output logic [MAX_HITS*ENTRY_W-1:0] sel_list_o,
  output logic [CNT_W-1:0]            sel_count_o,
  output logic                        done_o,
  output logic                        render_mode_o
);
  logic              y_phase;
  logic              tail;
  logic [BYTE_W-1:0] entry_base;
  logic              eval;
  logic              skip;
  logic              cand_valid;
  sel_entry_t        cand;

  oam_scan_seq #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .ENTRY_BYTES(ENTRY_BYTES),
    .AW         (BYTE_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .active_o    (mem_rd_o),
    .mem_addr_o  (mem_addr_o),
    .entry_base_o(entry_base),
    .y_phase_o   (y_phase),
    .tail_o      (tail),
    .done_o      (done_o),
    .render_o    (render_mode_o)
  );

  oam_scan_match #(
    .OBJ_SHORT  (OBJ_SHORT),
    .OBJ_TALL   (OBJ_TALL),
    .LINE_OFFSET(LINE_OFFSET)
  ) u_match (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .y_phase_i   (y_phase),
    .entry_base_i(entry_base),
    .mem_data_i  (mem_data_i),
    .line_i      (line_i),
    .tall_i      (tall_i),
    .dma_busy_i  (dma_busy_i),
    .eval_o      (eval),
    .skip_o      (skip),
    .cand_valid_o(cand_valid),
    .cand_o      (cand)
  );

  oam_scan_list #(
    .MAX_HITS(MAX_HITS),
    .CNT_W   (CNT_W)
  ) u_list (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .cand_valid_i(cand_valid),
    .cand_i      (cand),
    .list_o      (sel_list_o),
    .count_o     (sel_count_o)
  );

  // R7
  dma_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (eval && skip && !start_i) |=> $stable(sel_count_o));
  // R8
  last_judged_chk: assert property (@(posedge clk) disable iff (rst)
    tail |-> (eval && !mem_rd_o));
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!mem_rd_o && render_mode_o));
endmodule

// File: tb/oam_scan_selector_tb.sv
module oam_scan_selector_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [7:0]   line_i = '0;
  logic         tall_i = 1'b0;
  logic         dma_busy_i = 1'b0;
  logic         mem_rd_o;
  logic [7:0]   mem_addr_o;
  logic [7:0]   mem_data_i;
  logic [239:0] sel_list_o;
  logic [3:0]   sel_count_o;
  logic         done_o;
  logic         render_mode_o;

  int n_cmp = 0;
  int n_bad = 0;

  logic [7:0] mem [0:159];
  logic       dmask [0:39];
  int         exp_words [$];
  int         exp_cnt [$];
  string      exp_tag [$];

  always #2.5 clk = ~clk;

  always @(posedge clk) mem_data_i <= mem[mem_addr_o];

  oam_scan_selector u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .line_i(line_i), .tall_i(tall_i),
    .dma_busy_i(dma_busy_i), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
    .mem_data_i(mem_data_i), .sel_list_o(sel_list_o), .sel_count_o(sel_count_o),
    .done_o(done_o), .render_mode_o(render_mode_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: on every completion pulse pop one expected list and compare.
  always @(negedge clk) begin
    if (!rst && done_o) begin
      if (exp_cnt.size() == 0) begin
        check("R9 unexpected done", 1, 0);
      end else begin
        int n;
        string t;
        n = exp_cnt.pop_front();
        t = exp_tag.pop_front();
        check({t, " R8 count"}, int'(sel_count_o), n);
        for (int k = 0; k < 10; k++) begin
          int e;
          e = (k < n) ? exp_words.pop_front() : 0;
          check({t, " R5 slot"}, int'(sel_list_o[k*24 +: 24]), e);
        end
      end
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < 160; i++) mem[i] = 8'(i * 3 + 1);
    for (int j = 0; j < 40; j++) begin
      mem[4*j] = 8'd0;
      dmask[j] = 1'b0;
    end
  endtask

  task automatic set_obj(input int j, input int y, input int x);
    mem[4*j]   = 8'(y);
    mem[4*j+1] = 8'(x);
  endtask

  // Driver: computes the expected list from the rules and pushes it.
  task automatic push_expected(input string tag);
    int n = 0;
    int h = tall_i ? 16 : 8;
    int l = int'(line_i) + 16;
    for (int j = 0; j < 40; j++) begin
      int y = int'(mem[4*j]);
      if (!dmask[j] && y <= l && l < y + h && n < 10) begin
        exp_words.push_back((4*j << 16) | (y << 8) | int'(mem[4*j+1]));
        n++;
      end
    end
    exp_cnt.push_back(n);
    exp_tag.push_back(tag);
  endtask

  task automatic run_scan(input string tag, input int line, input logic tall);
    line_i = 8'(line);
    tall_i = tall;
    push_expected(tag);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R9 count cleared", int'(sel_count_o), 0);
    check("R9 render cleared", int'(render_mode_o), 0);
    for (int c = 0; c < 80; c++) begin
      int ea = 4 * (c / 2) + (c % 2);
      if (mem_addr_o != 8'(ea) || !mem_rd_o) check("R2 addr/rd", int'(mem_addr_o), ea);
      else n_cmp++;
      dma_busy_i = dmask[c/2];
      @(negedge clk);
    end
    dma_busy_i = 1'b0;
    check("R2 rd low", int'(mem_rd_o), 0);
    check("R8 early done", int'(done_o), 0);
    @(negedge clk);
    check("R8 done", int'(done_o), 1);
    check("R8 render", int'(render_mode_o), 1);
    @(negedge clk);
    check("R8 done width", int'(done_o), 0);
    check("R8 render hold", int'(render_mode_o), 1);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (1_000_000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 count", int'(sel_count_o), 0);
    check("R1 list", int'(sel_list_o != '0), 0);
    check("R1 done", int'(done_o), 0);
    check("R1 render", int'(render_mode_o), 0);
    check("R1 rd", int'(mem_rd_o), 0);

    set_obj(2, 16, 5);
    set_obj(5, 9, 7);
    set_obj(6, 8, 9);
    set_obj(7, 17, 11);
    set_obj(10, 12, 200);
    set_obj(12, 1, 44);
    run_scan("R3 short", 0, 1'b0);
    run_scan("R4 tall", 0, 1'b1);

    clear_mem();
    for (int j = 0; j < 40; j++) set_obj(j, 60 + j % 5, j + 1);
    run_scan("R6 cap", 50, 1'b0);
    for (int j = 0; j < 40; j++) dmask[j] = (j % 2 == 0);
    run_scan("R7 dma", 50, 1'b0);

    clear_mem();
    set_obj(39, 30, 99);
    run_scan("R8 last", 20, 1'b0);

    clear_mem();
    for (int j = 0; j < 40; j++) set_obj(j, 60 + j % 5, j + 1);
    line_i = 8'd50;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (30) @(negedge clk);
    check("R9 partial scan stored", int'(sel_count_o > 0), 1);
    run_scan("R9 restart", 50, 1'b0);

    clear_mem();
    for (int j = 0; j < 40; j++) set_obj(j, (j * 37 + 11) % 256, 255 - j);
    run_scan("R3 mixed", 143, 1'b0);
    run_scan("R4 mixed", 143, 1'b1);

    repeat (4) @(negedge clk);
    check("R8 all scans completed", exp_cnt.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule